// File: doc/BRIEF.md
# Hamming Sector Syndrome Corrector

This block finishes the repair step for a 512-byte storage sector that is protected by a 24-bit Hamming parity code. It receives two codes: the one computed over the data as the data was read, and the one that was written alongside the sector in its spare bytes. The block XORs them into a syndrome and counts the ones in that syndrome. From the count it sorts the sector into one of four classes: clean, one flipped data bit that can be repaired, damage too heavy to repair, or damage to the parity field itself.

For a repairable sector the block reads the position of the bad bit straight from the odd-numbered syndrome bits and reports a byte offset and a bit index. If repair is requested, it then does a read-modify-write on a byte-wide, block-RAM style port to the sector buffer and inverts that one bit. It raises its done pulse only after the write. The parity code itself is computed elsewhere.

Top module: `hecc_sector_fix`

## Requirements
- R1: A `start` seen while the block is idle latches the syndrome `code_calc ^ code_stored` (byte 0 in bits [7:0]). A syndrome of all zeros gives `status` 2'b00 (clean).
- R2: A syndrome with exactly 12 ones gives `status` 2'b01 (single correctable data bit).
- R3: A syndrome with 1 to 22 ones, other than 12, gives `status` 2'b10 (uncorrectable).
- R4: A syndrome with 23 or 24 ones gives `status` 2'b11 (parity field error).
- R5: For `status` 2'b01, `err_bit` holds syndrome bits 1, 3 and 5, with bit 1 as the least significant.
- R6: For `status` 2'b01, `err_byte` holds syndrome bits 7, 9, 11, 13, 15, 17, 19, 21 and 23, with bit 7 as the least significant.
- R7: When `status` is not 2'b01, `err_byte` and `err_bit` are zero.
- R8: `done` is high for exactly one cycle. `status`, `err_byte` and `err_bit` are valid while it is high.
- R9: With no RAM repair, `done` rises on the first rising clock edge after the edge that samples `start`.
- R10: With `fix_en` high and `status` 2'b01, the block reads the RAM byte at `err_byte` (read data returns one cycle after `ram_rd_en`). It then writes exactly one byte back to that address with bit `err_bit` inverted. `done` rises on the fourth edge after the start edge, and the write is complete by then.
- R11: When `fix_en` is low, or `status` is not 2'b01, the block makes no RAM write.
- R12: A `start` that arrives while an operation is in progress is ignored. That operation's result is not changed.
- R13: While and right after reset, `done`, `ram_rd_en` and `ram_wr_en` are low and `status` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts one classification; accepted only when idle |
| fix_en | input | 1 | Repair the sector RAM when the error is correctable |
| code_calc | input | 24 | Parity code computed over the data read |
| code_stored | input | 24 | Parity code read from the spare bytes |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 single, 10 uncorrectable, 11 field error |
| err_byte | output | 9 | Byte offset of the bad bit |
| err_bit | output | 3 | Bit index of the bad bit within the byte |
| ram_addr | output | 9 | Sector RAM byte address |
| ram_rd_en | output | 1 | Sector RAM read strobe |
| ram_rdata | input | 8 | Sector RAM read data, one cycle after the strobe |
| ram_wr_en | output | 1 | Sector RAM write strobe |
| ram_wdata | output | 8 | Sector RAM write data |

## Verification
The assertions take for granted that the attached RAM returns read data exactly one cycle after `ram_rd_en` and holds it until the next read. They also take for granted that `ram_rdata` reflects the addressed byte. The bench's RAM model is a synchronous-read array driven only by the block's own strobes, so both assumptions hold by construction. `start` is driven at falling edges only. Single-bit syndromes are built as complementary bit pairs, so every correctable case has a well-formed location. Other ones counts are chosen directly to hit each class boundary.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_SINGLE = 2'b01,
    ST_MULTI  = 2'b10,
    ST_FIELD  = 2'b11
  } hecc_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_RD,
    S_MOD,
    S_WR
  } hecc_state_e;
endpackage

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int CODE_W = 24
) (
  input  logic [CODE_W-1:0] syn,
  output hecc_status_e      cls
);
  localparam int CNT_W     = $clog2(CODE_W + 1);
  localparam int HALF      = CODE_W / 2;
  localparam int FIELD_MIN = CODE_W - 1;

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) begin
      ones = ones + CNT_W'(syn[i]);
    end
  end

  always_comb begin
    if (ones == '0)                        cls = ST_CLEAN;
    else if (ones >= CNT_W'(FIELD_MIN))    cls = ST_FIELD;
    else if (ones == CNT_W'(HALF))         cls = ST_SINGLE;
    else                                   cls = ST_MULTI;
  end
endmodule

// File: rtl/hecc_locate.sv
module hecc_locate #(
  parameter int CODE_W = 24,
  parameter int BIT_W  = 3,
  parameter int OFF_W  = 9
) (
  input  logic [CODE_W-1:0] syn,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [OFF_W-1:0]  byte_off
);
  localparam int LOC_W = CODE_W / 2;

  logic [LOC_W-1:0] loc;

  for (genvar k = 0; k < LOC_W; k++) begin : g_odd
    assign loc[k] = syn[2*k+1];
  end

  assign bit_idx  = loc[BIT_W-1:0];
  assign byte_off = loc[LOC_W-1:BIT_W];
endmodule

// File: rtl/hecc_sector_fix.sv
module hecc_sector_fix
  import hecc_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int BIT_W  = 3,
  localparam int LOC_W  = CODE_W / 2,
  localparam int OFF_W  = LOC_W - BIT_W,
  localparam int DATA_W = 1 << BIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fix_en,
  input  logic [CODE_W-1:0] code_calc,
  input  logic [CODE_W-1:0] code_stored,
  output logic              done,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  err_byte,
  output logic [BIT_W-1:0]  err_bit,
  output logic [OFF_W-1:0]  ram_addr,
  output logic              ram_rd_en,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_wr_en,
  output logic [DATA_W-1:0] ram_wdata
);
  hecc_state_e       state;
  logic [CODE_W-1:0] syn_q;
  logic              fix_q;
  hecc_status_e      cls;
  hecc_status_e      status_q;
  logic [BIT_W-1:0]  bit_idx;
  logic [OFF_W-1:0]  byte_off;

  hecc_classify #(.CODE_W(CODE_W)) u_cls (
    .syn (syn_q),
    .cls (cls)
  );

  hecc_locate #(.CODE_W(CODE_W), .BIT_W(BIT_W), .OFF_W(OFF_W)) u_loc (
    .syn      (syn_q),
    .bit_idx  (bit_idx),
    .byte_off (byte_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      syn_q     <= '0;
      fix_q     <= 1'b0;
      status_q  <= ST_CLEAN;
      err_byte  <= '0;
      err_bit   <= '0;
      done      <= 1'b0;
      ram_addr  <= '0;
      ram_rd_en <= 1'b0;
      ram_wr_en <= 1'b0;
      ram_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            syn_q <= code_calc ^ code_stored;
            fix_q <= fix_en;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          status_q <= cls;
          if (cls == ST_SINGLE) begin
            err_byte <= byte_off;
            err_bit  <= bit_idx;
          end else begin
            err_byte <= '0;
            err_bit  <= '0;
          end
          if (cls == ST_SINGLE && fix_q) begin
            ram_addr  <= byte_off;
            ram_rd_en <= 1'b1;
            state     <= S_RD;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_RD: begin
          ram_rd_en <= 1'b0;
          state     <= S_MOD;
        end
        S_MOD: begin
          ram_wdata <= ram_rdata ^ (DATA_W'(1) << err_bit);
          ram_wr_en <= 1'b1;
          state     <= S_WR;
        end
        S_WR: begin
          ram_wr_en <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign status = status_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ram_rd_en && ram_wr_en));

  // R11
  wr_status_chk: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> status == ST_SINGLE);

  // R10
  wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> ram_addr == err_byte);

  // R10
  wr_flip_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_wr_en) |-> $countones(ram_wdata ^ $past(ram_rdata)) == 1);

  // R7
  clean_loc_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status != ST_SINGLE) |-> (err_byte == '0 && err_bit == '0));
endmodule

// File: tb/hecc_sector_fix_test.sv
module hecc_sector_fix_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        fix_en = 1'b0;
  logic [23:0] code_calc = '0;
  logic [23:0] code_stored = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic [8:0]  ram_addr;
  logic        ram_rd_en;
  logic [7:0]  ram_rdata;
  logic        ram_wr_en;
  logic [7:0]  ram_wdata;

  int checks = 0;
  int failures = 0;
  int writes = 0;
  bit finished = 0;
  logic [7:0] mem [512];

  always #2 clk = ~clk;

  hecc_sector_fix uut (
    .clk(clk), .rst(rst), .start(start), .fix_en(fix_en),
    .code_calc(code_calc), .code_stored(code_stored),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
    .ram_addr(ram_addr), .ram_rd_en(ram_rd_en), .ram_rdata(ram_rdata),
    .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata)
  );

  always @(posedge clk) begin
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
    if (ram_wr_en) begin
      mem[ram_addr] <= ram_wdata;
      writes <= writes + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_single(input int byt, input int bt);
    logic [11:0] loc;
    logic [23:0] s;
    loc = {byt[8:0], bt[2:0]};
    for (int k = 0; k < 12; k++) begin
      s[2*k+1] = loc[k];
      s[2*k]   = ~loc[k];
    end
    return s;
  endfunction

  // Runs one operation; optionally fires a second start while busy.
  task automatic run(input logic [23:0] calc, input logic [23:0] syn, input bit fix,
                     input bit extra, output int lat);
    int dones;
    @(negedge clk);
    code_calc = calc; code_stored = calc ^ syn; fix_en = fix; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    dones = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (extra && i == 0) begin
        code_calc = 24'h123456; code_stored = 24'h123456; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
  endtask

  task automatic after_done(input string tag);
    @(negedge clk);
    chk(!done, tag, done, 0);
  endtask

  task automatic t_reset;
    chk(done == 0 && ram_rd_en == 0 && ram_wr_en == 0, "R13 strobes", {done, ram_rd_en, ram_wr_en}, 0);
    chk(status == 2'b00, "R13 status", status, 0);
  endtask

  task automatic t_clean;
    int lat;
    run(24'h5A3C81, 24'h000000, 1'b1, 1'b0, lat);
    chk(done, "R1 done", done, 1);
    chk(status == 2'b00, "R1 clean status", status, 0);
    chk(err_byte == 0 && err_bit == 0, "R7 clean loc", {err_byte, err_bit}, 0);
    chk(lat == 1, "R9 latency", lat, 1);
    after_done("R8 pulse clean");
  endtask

  task automatic t_single_nofix(input int byt, input int bt);
    int lat, w0;
    w0 = writes;
    run(24'hC0FFEE, mk_single(byt, bt), 1'b0, 1'b0, lat);
    chk(status == 2'b01, "R2 single status", status, 1);
    chk(err_bit == bt[2:0], "R5 bit index", err_bit, bt);
    chk(err_byte == byt[8:0], "R6 byte offset", err_byte, byt);
    chk(lat == 1, "R9 latency nofix", lat, 1);
    chk(writes == w0, "R11 no write nofix", writes - w0, 0);
    after_done("R8 pulse single");
  endtask

  task automatic t_single_fix(input int byt, input int bt);
    int lat, w0, nb;
    logic [7:0] orig, nbv;
    nb = (byt + 1) % 512;
    orig = mem[byt]; nbv = mem[nb];
    w0 = writes;
    run(24'h0BEEF1, mk_single(byt, bt), 1'b1, 1'b0, lat);
    chk(status == 2'b01, "R2 fix status", status, 1);
    chk(err_byte == byt[8:0] && err_bit == bt[2:0], "R6 fix loc", {err_byte, err_bit}, {byt[8:0], bt[2:0]});
    chk(lat == 4, "R10 latency", lat, 4);
    chk(mem[byt] == (orig ^ (8'd1 << bt)), "R10 flipped byte", mem[byt], orig ^ (8'd1 << bt));
    chk(mem[nb] == nbv, "R10 neighbour kept", mem[nb], nbv);
    chk(writes - w0 == 1, "R10 one write", writes - w0, 1);
    after_done("R8 pulse fix");
  endtask

  task automatic t_class(input logic [23:0] syn, input int exp_st, input string tag);
    int lat, w0;
    w0 = writes;
    run(24'h777777, syn, 1'b1, 1'b0, lat);
    chk(status == exp_st[1:0], tag, status, exp_st);
    chk(err_byte == 0 && err_bit == 0, "R7 loc zero", {err_byte, err_bit}, 0);
    chk(writes == w0, "R11 no write", writes - w0, 0);
    chk(lat == 1, "R9 latency class", lat, 1);
  endtask

  task automatic t_busy;
    int lat, w0;
    logic [7:0] orig;
    orig = mem[10];
    w0 = writes;
    run(24'h00AA55, mk_single(10, 1), 1'b1, 1'b1, lat);
    chk(status == 2'b01 && err_byte == 10 && err_bit == 1, "R12 busy start ignored",
        {status, err_byte, err_bit}, {2'b01, 9'd10, 3'd1});
    chk(lat == 4, "R12 latency kept", lat, 4);
    chk(mem[10] == (orig ^ 8'h02), "R12 repair kept", mem[10], orig ^ 8'h02);
    repeat (4) begin
      @(negedge clk);
      chk(!done, "R12 no second done", done, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single_nofix(9'h1A5, 6);
    t_single_fix(300, 3);
    t_single_fix(511, 7);
    t_single_fix(0, 0);
    t_class(24'h000001, 2, "R3 one bit");
    t_class(24'h001FFF, 2, "R3 thirteen ones");
    t_class(24'h3FFFFF, 2, "R3 twenty-two ones");
    t_class(24'hFFFFFE, 3, "R4 twenty-three ones");
    t_class(24'hFFFFFF, 3, "R4 twenty-four ones");
    t_busy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule